// File: doc/BRIEF.md
# Boost Converter Pulse Scheduler

This block decides when the gate driver of an inductor boost converter gets a switching pulse. It runs on a fast system clock. The converter's oscillators reach it as one-cycle clock-enable strobes in that clock domain. A slow reference clock of about 32 kHz, which is not related to the system clock, enters through a synchroniser.

In the regulating (active) mode, a two-bit rate code chooses what produces each pulse. The codes are:

| Code | Pulse source |
|------|--------------|
| 0 | 100 kHz strobe |
| 1 | 400 kHz strobe |
| 2 | 2 MHz strobe |
| 3 | Rising edge of the synchronised reference |

In the low-power (standby) mode, the rate code and the strobes are ignored. A pulse is issued on every rising edge and every falling edge of the reference, but only when the output-below-target comparator flag is high in the cycle the edge is detected.

A state machine sequences the block through four states:

| State | Meaning |
|-------|---------|
| `S_OFF` | Disabled |
| `S_PRIME` | Synchroniser refill |
| `S_ACTIVE` | Regulating |
| `S_STANDBY` | Low power |

Its transitions are:

| Transition | Condition |
|------------|-----------|
| `OFF→PRIME` | enable high |
| `PRIME→ACTIVE` | priming count done, standby low |
| `PRIME→STANDBY` | priming count done, standby high |
| `ACTIVE→STANDBY` | standby rises |
| `STANDBY→ACTIVE` | standby falls |
| `any→OFF` | enable low |

The edge detector is held clear in `S_OFF`. `S_PRIME` lasts SYNC_STAGES+1 cycles and suppresses pulses, so the level of the reference at enable time is never mistaken for an edge.

Top module: `boost_pulse_sched`

## Requirements
- R1: While rst_n is low, gate_pulse is low.
- R2: In active mode with rate code 0, 1 or 2, gate_pulse pulses once for each strobe on osc_tick[code], in the cycle after the strobe is sampled. Strobes on the other osc_tick bits are ignored.
- R3: In active mode with rate code 3, gate_pulse pulses once per rising edge of ref_clk_in. Falling edges and all osc_tick strobes are ignored.
- R4: In standby mode, every rising and every falling edge of ref_clk_in yields exactly one pulse when below_target is high in the cycle the synchronised edge is detected. That cycle is SYNC_STAGES system-clock edges after the change.
- R5: In standby mode, an edge detected while below_target is low yields no pulse.
- R6: In standby mode, rate_sel and osc_tick have no effect on gate_pulse.
- R7: gate_pulse is never high in two consecutive cycles.
- R8: While enable is low, gate_pulse is low from the next cycle on, and the synchroniser and edge history are cleared.
- R9: After enable rises, no pulse is issued for SYNC_STAGES+1 cycles. A steady reference level present at enable time, high or low, never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces S_OFF |
| standby_mode | input | 1 | 1 = standby (edge-triggered), 0 = active |
| rate_sel | input | 2 | Active rate code: 0 = 100 kHz, 1 = 400 kHz, 2 = 2 MHz, 3 = reference rising edge |
| osc_tick | input | 3 | One-cycle oscillator strobes; bit 0 = 100 kHz, bit 1 = 400 kHz, bit 2 = 2 MHz |
| ref_clk_in | input | 1 | Asynchronous slow reference clock |
| below_target | input | 1 | Comparator: output below programmed target |
| gate_pulse | output | 1 | One-cycle gate pulse strobe |

## Verification
In active mode, all three strobes run together at different periods while each rate code is selected. Each pulse count must match the selected strobe alone, which tells apart a wrong mux leg from a correct one. Code 3 is driven with a toggling reference, and the count must equal the rising edges only, which separates single-edge from double-edge detection. Standby runs use the flag held high, held low and randomised per half-period, with random rate codes and live strobes, which shows both-edge firing, the gating by the flag and the independence from the rate controls. Disable and re-enable with the reference parked high, and mode switches in both directions, expose spurious edges from a stale synchroniser.

// File: rtl/boost_pulse_pkg.sv
package boost_pulse_pkg;
    localparam int RATE_W  = 2;
    localparam int NUM_OSC = 3;

    typedef enum logic [1:0] {
        S_OFF     = 2'd0,
        S_PRIME   = 2'd1,
        S_ACTIVE  = 2'd2,
        S_STANDBY = 2'd3
    } sched_state_t;
endpackage

// File: rtl/ref_edge_detect.sv
module ref_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref_in,
    output logic ref_rise,
    output logic ref_fall
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else if (clear) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], ref_in};
            prev_q <= sync_q[MSB];
        end
    end

    assign ref_rise = sync_q[MSB] & ~prev_q;
    assign ref_fall = ~sync_q[MSB] & prev_q;

    // R8
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!ref_rise && !ref_fall));
endmodule

// File: rtl/rate_tick_select.sv
module rate_tick_select
    import boost_pulse_pkg::*;
#(
    parameter int N_OSC = NUM_OSC
) (
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [N_OSC-1:0]  osc_tick,
    input  logic              ref_rise,
    output logic              sel_tick
);
    localparam int N_SRC = N_OSC + 1;

    logic [N_SRC-1:0] src;

    genvar gi;
    generate
        for (gi = 0; gi < N_OSC; gi++) begin : g_osc
            assign src[gi] = osc_tick[gi];
        end
    endgenerate
    assign src[N_OSC] = ref_rise;

    always_comb begin
        sel_tick = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (int'(rate_sel) == k) sel_tick = src[k];
        end
    end
endmodule

// File: rtl/pulse_fsm.sv
module pulse_fsm
    import boost_pulse_pkg::*;
#(
    parameter int PRIME_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic standby,
    input  logic sel_tick,
    input  logic ref_rise,
    input  logic ref_fall,
    input  logic below,
    output logic det_clear,
    output logic gate_pulse
);
    localparam int CNT_W = $clog2(PRIME_CYCLES + 1);
    localparam logic [CNT_W-1:0] PRIME_LAST = CNT_W'(PRIME_CYCLES - 1);

    sched_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic fire;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:     state_d = S_PRIME;
                S_PRIME:   if (cnt_q == PRIME_LAST)
                               state_d = standby ? S_STANDBY : S_ACTIVE;
                S_ACTIVE:  if (standby)  state_d = S_STANDBY;
                S_STANDBY: if (!standby) state_d = S_ACTIVE;
                default:   state_d = S_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == S_PRIME) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            S_ACTIVE:  fire = sel_tick;
            S_STANDBY: fire = (ref_rise | ref_fall) & below;
            default:   fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gate_pulse <= 1'b0;
        else if (!enable) gate_pulse <= 1'b0;
        else              gate_pulse <= fire & ~gate_pulse;
    end

    assign det_clear = (state_q == S_OFF);

    // R7
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pulse |=> !gate_pulse);
    // R8
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate_pulse);
    // R9
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> !gate_pulse);
    // R5
    below_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_pulse && $past(state_q == S_STANDBY)) |-> $past(below));
    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> !gate_pulse);
endmodule

// File: rtl/boost_pulse_sched.sv
module boost_pulse_sched
    import boost_pulse_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              standby_mode,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [NUM_OSC-1:0] osc_tick,
    input  logic              ref_clk_in,
    input  logic              below_target,
    output logic              gate_pulse
);
    localparam int PRIME_CYCLES = SYNC_STAGES + 1;

    logic ref_rise, ref_fall, sel_tick, det_clear;

    ref_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (det_clear),
        .ref_in   (ref_clk_in),
        .ref_rise (ref_rise),
        .ref_fall (ref_fall)
    );

    rate_tick_select #(.N_OSC(NUM_OSC)) u_sel (
        .rate_sel (rate_sel),
        .osc_tick (osc_tick),
        .ref_rise (ref_rise),
        .sel_tick (sel_tick)
    );

    pulse_fsm #(.PRIME_CYCLES(PRIME_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .standby    (standby_mode),
        .sel_tick   (sel_tick),
        .ref_rise   (ref_rise),
        .ref_fall   (ref_fall),
        .below      (below_target),
        .det_clear  (det_clear),
        .gate_pulse (gate_pulse)
    );
endmodule

// File: tb/boost_pulse_sched_test.sv
`timescale 1ns/1ps
module boost_pulse_sched_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       standby_mode = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [2:0] osc_tick = 3'b000;
    logic       ref_clk_in = 1'b0;
    logic       below_target = 1'b0;
    logic       gate_pulse;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int doubles = 0;
    bit tick_run = 1'b0;
    int issued [3];
    int phase [3];
    int period [3] = '{40, 10, 3};
    bit prev_gate = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boost_pulse_sched uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .standby_mode(standby_mode),
        .rate_sel(rate_sel), .osc_tick(osc_tick), .ref_clk_in(ref_clk_in),
        .below_target(below_target), .gate_pulse(gate_pulse)
    );

    always @(negedge clk) begin
        if (gate_pulse) pulses++;
        if (gate_pulse && prev_gate) doubles++;
        prev_gate = gate_pulse;
        for (int i = 0; i < 3; i++) begin
            if (tick_run && phase[i] == period[i] - 1) begin
                phase[i] = 0;
                osc_tick[i] = 1'b1;
                issued[i]++;
            end else begin
                if (tick_run) phase[i]++;
                osc_tick[i] = 1'b0;
            end
        end
    end

    function automatic int expected_count(bit stby, int rate, int n0, int n1,
                                          int n2, int rises, int below_edges);
        if (stby) return below_edges;
        case (rate)
            0: return n0;
            1: return n1;
            2: return n2;
            default: return rises;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic start_window();
        repeat (6) @(negedge clk);
        pulses = 0;
        doubles = 0;
        for (int i = 0; i < 3; i++) begin
            issued[i] = 0;
            phase[i] = int'($urandom_range(period[i] - 1));
        end
    endtask

    task automatic active_run(int rate, int cycles, int half);
        int rises = 0;
        standby_mode = 1'b0;
        rate_sel = 2'(rate);
        start_window();
        tick_run = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (half > 0 && c % half == half - 1) begin
                ref_clk_in = ~ref_clk_in;
                if (ref_clk_in) rises++;
            end
        end
        tick_run = 1'b0;
        repeat (8) @(negedge clk);
        // R2 R3: count follows the selected source only
        check(rate == 3 ? "R3" : "R2", pulses,
              expected_count(1'b0, rate, issued[0], issued[1], issued[2], rises, 0));
        // R7
        check("R7", doubles, 0);
    endtask

    task automatic standby_run(int edges, int bmode, string req);
        int be = 0;
        standby_mode = 1'b1;
        start_window();
        tick_run = 1'b1;
        for (int e = 0; e < edges; e++) begin
            bit b;
            b = (bmode == 2) ? bit'($urandom_range(1)) : bit'(bmode);
            rate_sel = 2'($urandom_range(3));
            ref_clk_in = ~ref_clk_in;
            below_target = b;
            if (b) be++;
            repeat ($urandom_range(15, 5)) @(negedge clk);
        end
        tick_run = 1'b0;
        repeat (8) @(negedge clk);
        check(req, pulses, expected_count(1'b1, 0, issued[0], issued[1], issued[2], 0, be));
        check("R7", doubles, 0);
    endtask

    initial begin
        #1_500_000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: output low in reset
        check("R1", int'(gate_pulse), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (10) @(negedge clk);

        active_run(0, 400, 0);
        active_run(1, 300, 0);
        active_run(2, 200, 0);
        active_run(3, 300, 9);

        standby_run(20, 1, "R4");
        standby_run(20, 0, "R5");
        standby_run(30, 2, "R6");

        // R8: disabled, reference and strobes moving
        start_window();
        enable = 1'b0;
        standby_mode = 1'b1;
        below_target = 1'b1;
        tick_run = 1'b1;
        for (int e = 0; e < 12; e++) begin
            ref_clk_in = ~ref_clk_in;
            repeat (7) @(negedge clk);
        end
        tick_run = 1'b0;
        check("R8", pulses, 0);

        // R9: re-enable with reference parked high, then low
        ref_clk_in = 1'b1;
        repeat (5) @(negedge clk);
        pulses = 0;
        enable = 1'b1;
        repeat (20) @(negedge clk);
        check("R9", pulses, 0);
        enable = 1'b0;
        ref_clk_in = 1'b0;
        repeat (5) @(negedge clk);
        pulses = 0;
        enable = 1'b1;
        repeat (20) @(negedge clk);
        check("R9", pulses, 0);

        // mixed random phases, switching modes both ways
        for (int it = 0; it < 8; it++) begin
            if ($urandom_range(1)) standby_run(10, 2, "R4");
            else active_run(int'($urandom_range(3)), 150, 7);
        end
        finish_run();
    end
endmodule